// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple synchronous request port to an external byte-wide asynchronous static memory with 128K locations. A requester offers a read or a write with a valid/ready handshake, a 17-bit address and a data byte. The controller then produces the memory control waveforms: an active-low select, an active-high select, an active-low write strobe, an active-low output enable, and a data bus split into an output byte, an input byte and a drive-enable that an external tri-state pad combines.

Each access is built from phases measured in clock cycles. A write has an address/data setup phase, a strobe phase and a hold phase. A read has one access phase, and the data is captured on the clock edge that ends it. The phase lengths are parameters. They must be chosen so that the cycle counts cover the memory's timing at the clock rate in use. Between any two accesses the controller returns to a deselected idle cycle. It reports each finished access with a one-cycle done pulse.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and in every idle cycle, `mem_sel_n`=1, `mem_sel_hi`=0, `mem_we_n`=1 and `mem_oe_n`=1, `mem_dq_oe`=0, and `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the access ends. A request offered while `req_ready` is 0 is ignored and leaves memory contents unchanged.
- R3: A write (`req_write`=1) has three phases in order. The setup phase lasts exactly T_SETUP cycles with the device selected, `mem_we_n`=1 and the data driven. The strobe phase then holds `mem_we_n`=0 for exactly T_STROBE cycles. The hold phase lasts exactly T_HOLD cycles with `mem_we_n`=1 and the device still selected. Address and data stay at the accepted values throughout all three phases.
- R4: `mem_addr` never changes between two consecutive cycles in which `mem_sel_n` and `mem_we_n` are both 0.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and `mem_oe_n` stays 1 for the whole of every write.
- R6: A read (`req_write`=0) holds `mem_oe_n`=0, `mem_we_n`=1 and the device selected for exactly T_ACCESS cycles. `mem_dq_in` is captured on the edge that ends this phase. The captured value appears on `rsp_rdata` in the following cycle and is held until the next read completes.
- R7: `rsp_done` is 1 for exactly one cycle per accepted request. That cycle is the idle cycle right after the last phase, so it comes T_SETUP+T_STROBE+T_HOLD+1 cycles after a write is accepted and T_ACCESS+1 cycles after a read is accepted.
- R8: Whenever `mem_sel_n` is 0, `mem_sel_hi` is 1. The device is therefore never half-selected during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle pulse when an access has finished |
| rsp_rdata | output | 8 | Data of the most recent read |
| mem_addr | output | 17 | Memory address lines |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Data returned from the memory bus |

## Verification
The bench goes after four things:
- The exact width of each phase. A design that is off by one in its counter would shorten the strobe or the hold, and the measured cycle counts would not match.
- Address stability while the write strobe and the select are both active. A design that updates the address too early would show a new address inside the strobe.
- Bus contention. A design that enables its driver while output enable is low would drive the bus against the memory.
- Requests offered while busy. A design that ignored `req_ready` would write a junk byte to a neighbouring address, and a later read-back against the bench's own memory image would show it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_WSETUP  = 3'd1,
      PH_WSTROBE = 3'd2,
      PH_WHOLD   = 3'd3,
      PH_RACCESS = 3'd4
   } phase_e;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
   parameter int unsigned AW = 17,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr <= '0;
         q_data <= '0;
      end else if (load) begin
         q_addr <= in_addr;
         q_data <= in_data;
      end
   end

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned MAX_LEN = 4,
   localparam int unsigned CW     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   generate
      if (MAX_LEN == 1) begin : g_single
         // every phase lasts one cycle: no counter needed
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, load, load_val};
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= load_val;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign last = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned T_SETUP  = 2,
   parameter int unsigned T_STROBE = 3,
   parameter int unsigned T_HOLD   = 1,
   parameter int unsigned T_ACCESS = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   req_write,
   output logic   accept,
   output phase_e phase_q,
   output phase_e phase_d,
   output logic   capture,
   output logic   done
);

   localparam int unsigned MAX_LEN = max_of4(T_SETUP, T_STROBE, T_HOLD, T_ACCESS);
   localparam int unsigned CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
   localparam logic [CW-1:0] LV_SETUP  = CW'(T_SETUP - 1);
   localparam logic [CW-1:0] LV_STROBE = CW'(T_STROBE - 1);
   localparam logic [CW-1:0] LV_HOLD   = CW'(T_HOLD - 1);
   localparam logic [CW-1:0] LV_ACCESS = CW'(T_ACCESS - 1);

   logic          load;
   logic [CW-1:0] load_val;
   logic          last;

   sram_phase_timer #(.MAX_LEN(MAX_LEN)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .last     (last)
   );

   assign accept = req_valid && (phase_q == PH_IDLE);

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      unique case (phase_q)
         PH_IDLE: if (req_valid) begin
            load     = 1'b1;
            phase_d  = req_write ? PH_WSETUP : PH_RACCESS;
            load_val = req_write ? LV_SETUP : LV_ACCESS;
         end
         PH_WSETUP: if (last) begin
            load     = 1'b1;
            phase_d  = PH_WSTROBE;
            load_val = LV_STROBE;
         end
         PH_WSTROBE: if (last) begin
            load     = 1'b1;
            phase_d  = PH_WHOLD;
            load_val = LV_HOLD;
         end
         PH_WHOLD:   if (last) phase_d = PH_IDLE;
         PH_RACCESS: if (last) phase_d = PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   assign capture = (phase_q == PH_RACCESS) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= last && (phase_q == PH_WHOLD || phase_q == PH_RACCESS);
      end
   end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned AW       = 17,
   parameter int unsigned DW       = 8,
   parameter int unsigned T_SETUP  = 2,
   parameter int unsigned T_STROBE = 3,
   parameter int unsigned T_HOLD   = 1,
   parameter int unsigned T_ACCESS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_sel_n,
   output logic          mem_sel_hi,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_ctrl: AW and DW must be at least 1");
      end
      if (T_SETUP < 1 || T_STROBE < 1 || T_HOLD < 1 || T_ACCESS < 1) begin : g_bad_len
         $error("sram_ctrl: every phase length must be at least one cycle");
      end
   endgenerate

   phase_e phase_q, phase_d;
   logic   accept, capture;

   sram_seq #(
      .T_SETUP  (T_SETUP),
      .T_STROBE (T_STROBE),
      .T_HOLD   (T_HOLD),
      .T_ACCESS (T_ACCESS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .accept    (accept),
      .phase_q   (phase_q),
      .phase_d   (phase_d),
      .capture   (capture),
      .done      (rsp_done)
   );

   sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .in_addr (req_addr),
      .in_data (req_wdata),
      .q_addr  (mem_addr),
      .q_data  (mem_dq_out)
   );

   assign req_ready = (phase_q == PH_IDLE);

   // strobes come straight from flops fed by the next-phase decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_sel_n  <= 1'b1;
         mem_sel_hi <= 1'b0;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         mem_sel_n  <= (phase_d == PH_IDLE);
         mem_sel_hi <= (phase_d != PH_IDLE);
         mem_we_n   <= (phase_d != PH_WSTROBE);
         mem_oe_n   <= (phase_d != PH_RACCESS);
         mem_dq_oe  <= (phase_d == PH_WSETUP) || (phase_d == PH_WSTROBE) ||
                       (phase_d == PH_WHOLD);
         if (capture) rsp_rdata <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
   parameter int unsigned AW = 17,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_done,
   input logic [AW-1:0] mem_addr,
   input logic          mem_sel_n,
   input logic          mem_sel_hi,
   input logic          mem_we_n,
   input logic          mem_oe_n,
   input logic [DW-1:0] mem_dq_out,
   input logic          mem_dq_oe
);

   AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel_hi && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($stable(mem_addr) && $past(!mem_sel_n) && $past(mem_dq_oe))); // R3

   AST_DATA_HELD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!mem_we_n) && mem_we_n) |-> (mem_dq_oe && !mem_sel_n && $stable(mem_dq_out))); // R3

   AST_ADDR_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel_n && !mem_we_n && $past(!mem_sel_n && !mem_we_n)) |-> $stable(mem_addr)); // R4

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R5

   AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_sel_n && !req_ready)); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R7

   AST_SELECT_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_sel_n |-> mem_sel_hi); // R8

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .mem_addr   (mem_addr),
   .mem_sel_n  (mem_sel_n),
   .mem_sel_hi (mem_sel_hi),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

   localparam int TS  = 2;
   localparam int TST = 3;
   localparam int TH  = 1;
   localparam int TA  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_sel_n, mem_sel_hi, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #4 clk = ~clk;   // 125 MHz

   sram_ctrl #(.T_SETUP(TS), .T_STROBE(TST), .T_HOLD(TH), .T_ACCESS(TA)) u_sram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel_hi(mem_sel_hi), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int total = 0;
   int failed = 0;
   bit finished = 1'b0;

   logic [7:0] model_mem [int];   // what the memory pins actually stored
   logic [7:0] exp_mem   [int];   // what the bench expects stored

   function automatic logic [7:0] blank_val(input logic [16:0] a);
      return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h3C;
   endfunction

   function automatic logic [7:0] exp_read(input logic [16:0] a);
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : blank_val(a);
   endfunction

   function automatic logic [7:0] model_read(input logic [16:0] a);
      return model_mem.exists(int'(a)) ? model_mem[int'(a)] : blank_val(a);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // memory pin model and protocol monitors, all sampled at the falling edge
   logic        p_sel_n = 1'b1, p_we_n = 1'b1;
   logic [16:0] p_addr = '0;
   logic [7:0]  p_dq = '0;
   int addr_moves = 0, contention = 0, half_sel = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_sel_n && !p_we_n && mem_we_n)
            model_mem[int'(p_addr)] = p_dq;
         if (!p_sel_n && !p_we_n && !mem_sel_n && !mem_we_n && mem_addr != p_addr)
            addr_moves++;
         if (mem_dq_oe && !mem_oe_n) contention++;
         if (!mem_sel_n && !mem_sel_hi) half_sel++;
      end
      mem_dq_in = (!mem_sel_n && mem_sel_hi && !mem_oe_n && mem_we_n) ?
                  model_read(mem_addr) : 8'hEE;
      p_sel_n = mem_sel_n;
      p_we_n  = mem_we_n;
      p_addr  = mem_addr;
      p_dq    = mem_dq_out;
   end

   // one request; entered and left just after a falling edge
   task automatic do_req(input bit w, input logic [16:0] a, input logic [7:0] d);
      int n, we_cnt, oe_cnt, setup_cnt, hold_cnt, bad_addr, bad_data, exp_n;
      n = 0; we_cnt = 0; oe_cnt = 0; setup_cnt = 0; hold_cnt = 0;
      bad_addr = 0; bad_data = 0;
      exp_n = w ? TS + TST + TH + 1 : TA + 1;
      chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      // offer a junk write while busy: must be ignored
      req_write = 1'b1; req_addr = a ^ 17'h1; req_wdata = ~d;
      chk(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
      forever begin
         n++;
         if (n == 2) req_valid = 1'b0;
         if (rsp_done || n > 200) break;
         if (!mem_sel_n && mem_addr != a) bad_addr++;
         if (mem_dq_oe && mem_dq_out != d) bad_data++;
         if (!mem_we_n) we_cnt++;
         else if (w && !mem_sel_n && we_cnt == 0) setup_cnt++;
         else if (w && !mem_sel_n) hold_cnt++;
         if (!mem_oe_n) oe_cnt++;
         @(negedge clk);
      end
      chk(n == exp_n, "R7", "cycles to done", n, exp_n);
      chk(mem_sel_n && !mem_sel_hi && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
          "R1", "idle pins at done", {mem_sel_n, mem_sel_hi, mem_we_n, mem_oe_n, mem_dq_oe, req_ready},
          6'b101101);
      chk(bad_addr == 0, "R3", "address held during access", bad_addr, 0);
      if (w) begin
         chk(setup_cnt == TS, "R3", "setup cycles", setup_cnt, TS);
         chk(we_cnt == TST, "R3", "strobe cycles", we_cnt, TST);
         chk(hold_cnt == TH, "R3", "hold cycles", hold_cnt, TH);
         chk(bad_data == 0, "R3", "write data held", bad_data, 0);
         chk(oe_cnt == 0, "R5", "output enable during write", oe_cnt, 0);
         exp_mem[int'(a)] = d;
      end else begin
         chk(oe_cnt == TA, "R6", "access cycles", oe_cnt, TA);
         chk(we_cnt == 0, "R6", "strobe during read", we_cnt, 0);
         chk(rsp_rdata == exp_read(a), "R6", "read data", int'(rsp_rdata), int'(exp_read(a)));
      end
      @(negedge clk);
      chk(rsp_done == 1'b0, "R7", "done lasts one cycle", int'(rsp_done), 0);
      if (!w)
         chk(rsp_rdata == exp_read(a), "R6", "read data held", int'(rsp_rdata), int'(exp_read(a)));
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(mem_sel_n && !mem_sel_hi && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
          "R1", "reset state", {mem_sel_n, mem_sel_hi, mem_we_n, mem_oe_n, mem_dq_oe, req_ready},
          6'b101101);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_done == 1'b0, "R7", "no done after reset", int'(rsp_done), 0);
      // directed corners: lowest and highest address, unwritten read, overwrite
      do_req(1'b0, 17'h00000, 8'h00);
      do_req(1'b1, 17'h00000, 8'hA5);
      do_req(1'b1, 17'h1FFFF, 8'h5A);
      do_req(1'b0, 17'h00000, 8'h00);
      do_req(1'b0, 17'h1FFFF, 8'h00);
      do_req(1'b1, 17'h1FFFF, 8'hFF);
      do_req(1'b0, 17'h1FFFF, 8'h00);
      do_req(1'b0, 17'h00001, 8'h00);   // neighbour of junk address: untouched (R2)
      // constrained random mix over a small address pool
      for (int i = 0; i < 80; i++) begin
         logic [16:0] a;
         case ($urandom % 4)
            0:       a = 17'h1FFFF;
            default: a = {13'h0A5C, 4'($urandom % 16)};
         endcase
         do_req(1'($urandom % 2), a, 8'($urandom));
      end
      for (int k = 0; k < 16; k++) do_req(1'b0, {13'h0A5C, 4'(k)}, 8'h00);
      chk(addr_moves == 0, "R4", "address moves inside strobe", addr_moves, 0);
      chk(contention == 0, "R5", "driver on with output enable", contention, 0);
      chk(half_sel == 0, "R8", "half-selected cycles", half_sel, 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

endmodule